// File: doc/BRIEF.md
# Controller Auto-Poll Sequencer

This block reads two serial game-controller ports by itself once per video frame. Each port has a 2-bit data input, so the block collects four 16-bit words in total. A slow strobe drives it; in the target system that strobe arrives every 128 system clocks, and an enable bit gates it. On each enabled strobe the sequencer takes one step through a fixed 33-step program:

- It pulses a latch line so the controllers capture their button state.
- It releases the latch and clears the result words.
- It then alternates between sampling the port data and clocking the ports so they present their next bit.

Polling begins when the vertical position reaches the visible-line limit and a strobe lands within a window of horizontal positions. After the last sample the sequencer parks in an idle state until the next start, and the four words keep their values for software to read.

The controllers' own shift registers are outside the block. The result words, the latch, the port clocks and a busy flag are all registered outputs that change on the clock edge at which an enabled strobe is sampled.

Top module: `joy_autopoll`

## Requirements
- R1: After reset the latch and both port clocks are low, busy is low and all four result words read zero.
- R2: Nothing changes unless the strobe is high while the enable is high. Strobes that arrive with the enable low are ignored, and the sequence resumes from the same step once the enable returns.
- R3: An enabled strobe starts a new sequence at step 0 when the vertical position equals the visible-line limit and the horizontal position lies between 130 and 256 inclusive. This happens even if a sequence is already in progress. Positions 129 and 257 do not start one.
- R4: Step 0 drives the latch high, and busy is high from then on.
- R5: Step 1 drives the latch low and clears all four result words to zero.
- R6: Each even step from 2 to 32 shifts every result word left by one bit and loads a new LSB. Word 0 takes port A bit 0, word 1 takes port B bit 0, word 2 takes port A bit 1 and word 3 takes port B bit 1. The first bit sampled therefore ends in bit 15.
- R7: Each odd step from 3 to 31 raises both port clocks for exactly one clock cycle, which gives 15 pulses per sequence. No other step pulses them.
- R8: After step 32 the step state is idle (value 33) and busy goes low. Further strobes change nothing until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | One-cycle pulse that advances the sequence |
| poll_en | input | 1 | Enables auto-polling |
| vpos | input | VW | Current vertical position |
| hpos | input | HW | Current horizontal position |
| vis_limit | input | VW | Visible-line limit (line on which polling starts) |
| port_a_data | input | 2 | Serial data bits from port A |
| port_b_data | input | 2 | Serial data bits from port B |
| latch_o | output | 1 | Latch line to both ports |
| port_a_clk | output | 1 | Clock pulse to port A |
| port_b_clk | output | 1 | Clock pulse to port B |
| busy | output | 1 | High while a sequence is in progress |
| word_a0 | output | NBITS | Bits collected from port A bit 0 |
| word_b0 | output | NBITS | Bits collected from port B bit 0 |
| word_a1 | output | NBITS | Bits collected from port A bit 1 |
| word_b1 | output | NBITS | Bits collected from port B bit 1 |

## Verification
A wrong step count shows up at the ports as soon as the frame ends. Either busy drops on the wrong strobe, or the number of port-clock pulses differs from 15. A misplaced sample or a port swap shows as a bit rotated or a word crossed over once the 33rd strobe has passed. A one-hot sweep across all 16 bit positions on each of the four lines therefore catches it within one frame. A gating fault shows on the very next ignored strobe, as a clock pulse or a change in a word.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_LATCH,
    ACT_CLEAR,
    ACT_SAMPLE,
    ACT_CLOCK
  } act_e;
endpackage

// File: rtl/autopoll_window.sv
module autopoll_window #(
  parameter int VW = 9,
  parameter int HW = 11,
  parameter int unsigned HLO = 130,
  parameter int unsigned HHI = 256
) (
  input  logic [VW-1:0] vpos,
  input  logic [VW-1:0] vis_limit,
  input  logic [HW-1:0] hpos,
  output logic          hit
);
  localparam logic [HW-1:0] LO = HW'(HLO);
  localparam logic [HW-1:0] HI = HW'(HHI);

  assign hit = (vpos == vis_limit) && (hpos >= LO) && (hpos <= HI);
endmodule

// File: rtl/autopoll_stepper.sv
module autopoll_stepper
  import autopoll_pkg::*;
#(
  parameter int NBITS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  input  logic restart,
  output act_e act,
  output logic latch_q,
  output logic pclk_q,
  output logic busy_q
);
  localparam int IDLE = 2 * NBITS + 1;
  localparam int CW   = $clog2(IDLE + 1);
  localparam logic [CW-1:0] IDLE_V = CW'(IDLE);

  logic [CW-1:0] step_q;
  logic [CW-1:0] eff;

  always_comb begin
    eff = restart ? '0 : step_q;
    if (!advance || eff >= IDLE_V) act = ACT_NONE;
    else if (eff == '0)            act = ACT_LATCH;
    else if (eff == CW'(1))        act = ACT_CLEAR;
    else if (!eff[0])              act = ACT_SAMPLE;
    else                           act = ACT_CLOCK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= IDLE_V;
      latch_q <= 1'b0;
      pclk_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      pclk_q <= (act == ACT_CLOCK);
      if (act != ACT_NONE) begin
        step_q <= eff + CW'(1);
        busy_q <= (eff + CW'(1)) != IDLE_V;
      end
      if (act == ACT_LATCH) latch_q <= 1'b1;
      if (act == ACT_CLEAR) latch_q <= 1'b0;
    end
  end
endmodule

// File: rtl/autopoll_shreg.sv
module autopoll_shreg #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift,
  input  logic             din,
  output logic [NBITS-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (shift) q <= {q[NBITS-2:0], din};
  end
endmodule

// File: rtl/joy_autopoll.sv
module joy_autopoll
  import autopoll_pkg::*;
#(
  parameter int VW    = 9,
  parameter int HW    = 11,
  parameter int NBITS = 16,
  parameter int unsigned HLO = 130,
  parameter int unsigned HHI = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             poll_en,
  input  logic [VW-1:0]    vpos,
  input  logic [HW-1:0]    hpos,
  input  logic [VW-1:0]    vis_limit,
  input  logic [1:0]       port_a_data,
  input  logic [1:0]       port_b_data,
  output logic             latch_o,
  output logic             port_a_clk,
  output logic             port_b_clk,
  output logic             busy,
  output logic [NBITS-1:0] word_a0,
  output logic [NBITS-1:0] word_b0,
  output logic [NBITS-1:0] word_a1,
  output logic [NBITS-1:0] word_b1
);
  localparam int NLANES = 4;

  logic hit;
  logic pclk;
  act_e act;
  logic [NLANES-1:0] lane_din;
  logic [NBITS-1:0]  lane_q [NLANES];

  autopoll_window #(.VW(VW), .HW(HW), .HLO(HLO), .HHI(HHI)) u_win (
    .vpos(vpos), .vis_limit(vis_limit), .hpos(hpos), .hit(hit)
  );

  autopoll_stepper #(.NBITS(NBITS)) u_step (
    .clk(clk), .rst(rst), .advance(strobe && poll_en), .restart(hit),
    .act(act), .latch_q(latch_o), .pclk_q(pclk), .busy_q(busy)
  );

  // lane order: A bit0, B bit0, A bit1, B bit1
  assign lane_din = {port_b_data[1], port_a_data[1], port_b_data[0], port_a_data[0]};

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    autopoll_shreg #(.NBITS(NBITS)) u_sr (
      .clk(clk), .rst(rst),
      .clr(act == ACT_CLEAR), .shift(act == ACT_SAMPLE),
      .din(lane_din[i]), .q(lane_q[i])
    );
  end

  assign port_a_clk = pclk;
  assign port_b_clk = pclk;
  assign word_a0 = lane_q[0];
  assign word_b0 = lane_q[1];
  assign word_a1 = lane_q[2];
  assign word_b1 = lane_q[3];
endmodule

// File: rtl/autopoll_chk.sv
module autopoll_chk #(
  parameter int NBITS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             strobe,
  input logic             poll_en,
  input logic             latch_o,
  input logic             port_a_clk,
  input logic             port_b_clk,
  input logic             busy,
  input logic [NBITS-1:0] word_a0,
  input logic [NBITS-1:0] word_b0,
  input logic [NBITS-1:0] word_a1,
  input logic [NBITS-1:0] word_b1
);
  p_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    !(strobe && poll_en) |=> ($stable(word_a0) && $stable(word_b0) && $stable(word_a1)
                              && $stable(word_b1) && $stable(busy) && $stable(latch_o)));

  p_latch_busy_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_o) |-> busy);

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(port_a_clk) |-> $past(strobe && poll_en));

  p_pulse_width_r7: assert property (@(posedge clk) disable iff (rst)
    port_a_clk |=> !port_a_clk);

  p_pulse_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (port_a_clk || port_b_clk) |-> (busy && !latch_o));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !latch_o);
endmodule

bind joy_autopoll autopoll_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .poll_en(poll_en),
  .latch_o(latch_o), .port_a_clk(port_a_clk), .port_b_clk(port_b_clk),
  .busy(busy), .word_a0(word_a0), .word_b0(word_b0),
  .word_a1(word_a1), .word_b1(word_b1)
);

// File: tb/sim_joy_autopoll.sv
`timescale 1ns/1ps
module sim_joy_autopoll;
  localparam int VW = 9, HW = 11, NB = 16;
  localparam logic [VW-1:0] LIM = 9'd224;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0, poll_en = 1'b0;
  logic [VW-1:0] vpos = '0, vis_limit = LIM;
  logic [HW-1:0] hpos = '0;
  logic [1:0] pa, pb;
  logic latch_o, port_a_clk, port_b_clk, busy;
  logic [NB-1:0] word_a0, word_b0, word_a1, word_b1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  joy_autopoll #(.VW(VW), .HW(HW), .NBITS(NB)) u0 (
    .clk(clk), .rst(rst), .strobe(strobe), .poll_en(poll_en),
    .vpos(vpos), .hpos(hpos), .vis_limit(vis_limit),
    .port_a_data(pa), .port_b_data(pb),
    .latch_o(latch_o), .port_a_clk(port_a_clk), .port_b_clk(port_b_clk), .busy(busy),
    .word_a0(word_a0), .word_b0(word_b0), .word_a1(word_a1), .word_b1(word_b1)
  );

  // controller model: load while latched, shift on port clock, MSB presented
  logic [NB-1:0] btn_a0, btn_b0, btn_a1, btn_b1;
  logic [NB-1:0] sa0, sa1, sb0, sb1;
  always @(posedge clk) begin
    if (latch_o) begin
      sa0 <= btn_a0; sa1 <= btn_a1; sb0 <= btn_b0; sb1 <= btn_b1;
    end else begin
      if (port_a_clk) begin sa0 <= sa0 << 1; sa1 <= sa1 << 1; end
      if (port_b_clk) begin sb0 <= sb0 << 1; sb1 <= sb1 << 1; end
    end
  end
  assign pa = {sa1[NB-1], sa0[NB-1]};
  assign pb = {sb1[NB-1], sb0[NB-1]};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_strobe();
    @(negedge clk) strobe = 1'b1;
    @(negedge clk) strobe = 1'b0;
  endtask

  task automatic check_words(input string req, input [NB-1:0] a0, b0, a1, b1);
    check(word_a0 == a0, req, word_a0, a0);
    check(word_b0 == b0, req, word_b0, b0);
    check(word_a1 == a1, req, word_a1, a1);
    check(word_b1 == b1, req, word_b1, b1);
  endtask

  // one full frame; start at hstart, optionally pause for 5 strobes at step pause_at
  task automatic run_frame(input [NB-1:0] a0, b0, a1, b1, input [HW-1:0] hstart, input int pause_at);
    int pulses = 0;
    btn_a0 = a0; btn_b0 = b0; btn_a1 = a1; btn_b1 = b1;
    poll_en = 1'b1; vpos = LIM; hpos = hstart;
    pulse_strobe();
    check(latch_o == 1'b1, "R4 latch high at step 0", latch_o, 1);
    check(busy == 1'b1, "R4 busy after start", busy, 1);
    vpos = LIM + 9'd1;
    pulse_strobe();
    check(latch_o == 1'b0, "R5 latch low at step 1", latch_o, 0);
    check_words("R5 clear at step 1", '0, '0, '0, '0);
    for (int s = 2; s <= 32; s++) begin
      if (s == pause_at) begin
        logic [NB-1:0] h0 = word_a0;
        poll_en = 1'b0;
        for (int k = 0; k < 5; k++) begin
          pulse_strobe();
          check(port_a_clk == 1'b0 && port_b_clk == 1'b0, "R2 no pulse while disabled", port_a_clk, 0);
          check(busy == 1'b1, "R2 busy held while disabled", busy, 1);
          check(word_a0 == h0, "R2 word frozen while disabled", word_a0, h0);
        end
        poll_en = 1'b1;
      end
      pulse_strobe();
      if (s % 2 == 1 && s >= 3) begin
        check(port_a_clk && port_b_clk, "R7 pulse on odd step", {port_a_clk, port_b_clk}, 2'b11);
        pulses++;
      end else begin
        check(!port_a_clk && !port_b_clk, "R7 no pulse on even step", {port_a_clk, port_b_clk}, 0);
      end
      @(negedge clk);
      check(!port_a_clk, "R7 pulse one cycle wide", port_a_clk, 0);
    end
    check(pulses == 15, "R7 pulse count", pulses, 15);
    check(busy == 1'b0, "R8 idle after step 32", busy, 0);
    check_words("R6 collected words", a0, b0, a1, b1);
    pulse_strobe();
    check(busy == 1'b0 && !port_a_clk, "R8 idle strobe no effect", {busy, port_a_clk}, 0);
    check_words("R8 words kept in idle", a0, b0, a1, b1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    btn_a0 = '0; btn_b0 = '0; btn_a1 = '0; btn_b1 = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!latch_o && !port_a_clk && !port_b_clk && !busy, "R1 reset outputs",
          {latch_o, port_a_clk, port_b_clk, busy}, 0);
    check_words("R1 reset words", '0, '0, '0, '0);

    // R2: enable low in window, R3: window boundaries
    poll_en = 1'b0; vpos = LIM; hpos = 11'd200;
    pulse_strobe();
    check(!busy && !latch_o, "R2 disabled strobe ignored", busy, 0);
    poll_en = 1'b1; hpos = 11'd129;
    pulse_strobe();
    check(!busy, "R3 hpos 129 no start", busy, 0);
    hpos = 11'd257;
    pulse_strobe();
    check(!busy, "R3 hpos 257 no start", busy, 0);
    vpos = LIM - 9'd1; hpos = 11'd200;
    pulse_strobe();
    check(!busy, "R3 wrong line no start", busy, 0);

    run_frame(16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF, 11'd130, 0);
    run_frame(16'h1234, 16'hFEDC, 16'h5A5A, 16'h0F0F, 11'd256, 9);
    // R6 sweep: one-hot across all positions, each lane distinct
    for (int k = 0; k < NB; k++) begin
      run_frame(NB'(1) << k, NB'(1) << ((k + 5) % NB), NB'(1) << ((k + 9) % NB),
                ~(NB'(1) << k), 11'd200, 0);
    end
    // R3 restart mid-sequence
    btn_a0 = 16'h3333; poll_en = 1'b1; vpos = LIM; hpos = 11'd180;
    pulse_strobe();
    vpos = LIM + 9'd1;
    repeat (7) pulse_strobe();
    check(busy == 1'b1, "R3 mid-sequence busy", busy, 1);
    run_frame(16'hC001, 16'h7FFE, 16'h0180, 16'h4242, 11'd140, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule